// File: doc/BRIEF.md
# Sample-and-Convert Sequencer

This block is the control engine of a 13-bit sampling converter. It holds the configuration register and decodes the commands written to it. It then runs fixed-length phases: a programmable acquisition window, a 44-clock conversion, a 78-clock offset trim and a 4946-clock full calibration. The successive-approximation datapath sits outside the block. A finished conversion is taken from the `conv_value` input at the clock edge that ends the conversion phase.

The sync pin works in one of two ways, chosen by a configuration bit. As an input, each rising edge starts a conversion straight away. As an output, it is high for exactly the clock cycles in which a conversion runs. An active-low ready line falls when an operation finishes, and an active-low standby line reports low power. The 4-bit channel code is decoded into a positive and a negative channel. Results are two's complement, are forced to zero in single-ended mode when negative, and are read as one 13-bit word or as two bytes.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `rdy_n`=1, `stby_n`=1, `sync_out`=0 and `sync_oe`=0. The configuration reset value is 0x100: sync-input mode, byte bus, channel code 0, so `pos_ch`=0 and `neg_ch`=1.
- R2: Configuration bit layout: [12] wide bus, [11:9] command, [8] sync-input mode, [7] high-byte select, [6] single-ended, [5:4] acquisition code, [3:0] channel code. In wide mode, one write loads all 13 bits and acts on the command. `sync_oe` equals the inverse of bit 8.
- R3: In byte mode, a write goes to bits [7:0] unless bit 7 is already set. When it is set, data bits [4:0] load bits [12:8], bit 7 is cleared, and the command is acted on. A write to the low byte never starts an operation.
- R4: Channel codes 0–7 give `pos_ch`=code and `neg_ch`=code XOR 1. Codes 8–15 give `pos_ch`=code[2:0] and `neg_ch`=8, the common input. `neg_ch` never equals `pos_ch`.
- R5: Command codes: 0 wake or no-op, 1 convert, 2 offset trim, 3 calibrate, 4 standby. In sync-output mode, the convert command runs an acquisition of 9, 15, 47 or 79 clocks (acquisition code 0–3) and then a 44-clock conversion. `sync_out` is high exactly during the conversion. `rdy_n` falls at the (N+44)th edge after the write edge.
- R6: In sync-input mode, a rising `sync_in` seen while idle starts a 44-clock conversion. `rdy_n` falls at the 44th edge after that edge, and `sync_out` stays low.
- R7: A `sync_in` rising edge during a conversion is ignored and produces no second result.
- R8: When the single-ended bit is set, a negative result (bit 12 set) is stored as 0. Positive results are stored unchanged, and with the bit clear every result is stored unchanged.
- R9: In wide mode, `rd_data` is the 13-bit result and a read raises `rdy_n`. In byte mode, the first read gives result[7:0] and the second gives result[12:8] sign-extended to 8 bits. Only the second read raises `rdy_n`. `rd_data`[12:8] is 0 in byte mode.
- R10: Any write that reaches the command field raises `rdy_n` on the following edge.
- R11: An offset trim makes `rdy_n` fall 78 edges after the write edge. A calibration makes it fall 4946 edges after.
- R12: A standby command drives `stby_n` low on the next edge. In standby, convert commands are ignored. A wake command raises `stby_n` on the next edge.
- R13: A command written while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 13 | Write data (byte mode uses [7:0]) |
| rd_en | input | 1 | One-cycle result read strobe |
| rd_data | output | 13 | Result word or current byte |
| conv_value | input | 13 | Datapath result, two's complement |
| sync_in | input | 1 | Sync pin input path |
| sync_out | output | 1 | Sync pin output path, conversion status |
| sync_oe | output | 1 | Sync pin output enable |
| rdy_n | output | 1 | Active-low operation-complete flag |
| stby_n | output | 1 | Active-low standby status |
| pos_ch | output | 3 | Positive mux channel |
| neg_ch | output | 4 | Negative mux channel, 8 = common |

## Verification
Every timed result is due a fixed number of edges after the edge that launched it. For sync-output conversions that is the acquisition length plus 44. For a sync edge it is 44, and it is 78 or 4946 for trim and calibration. Status, channel and read outputs are due one edge after their write or read. The driver stamps the launching edge with a cycle counter and pushes the due cycle into a queue. The monitor samples `rdy_n` on falling clock edges, and each fall must match the head of the queue exactly, while a fall with an empty queue fails. One-edge results are sampled on the falling edge right after the strobe.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int DATA_W  = 13;
  localparam int BYTE_W  = 8;
  localparam int CH_W    = 3;
  localparam int MUX_W   = CH_W + 1;
  localparam int HB_BIT  = 7;
  localparam logic [DATA_W-1:0] CFG_RST = 13'h100;

  typedef struct packed {
    logic       wide;
    logic [2:0] cmd;
    logic       sync_in_mode;
    logic       hi_sel;
    logic       single;
    logic [1:0] acq;
    logic [MUX_W-1:0] chan;
  } cfg_t;

  typedef enum logic [2:0] {
    CMD_WAKE  = 3'd0,
    CMD_CONV  = 3'd1,
    CMD_TRIM  = 3'd2,
    CMD_CAL   = 3'd3,
    CMD_SLEEP = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACQ, ST_CONV, ST_TRIM, ST_CAL, ST_SLEEP
  } st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg_q,
  output cfg_t              cfg_d,
  output logic              cmd_stb
);

  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] reg_d;
  logic              upper_wr;

  always_comb begin
    reg_d    = reg_q;
    upper_wr = 1'b0;
    if (wr_en) begin
      if (reg_q[DATA_W-1]) begin
        reg_d    = wr_data;
        upper_wr = 1'b1;
      end else if (reg_q[HB_BIT]) begin
        reg_d[DATA_W-1:BYTE_W] = wr_data[HI_W-1:0];
        reg_d[HB_BIT]          = 1'b0;
        upper_wr               = 1'b1;
      end else begin
        reg_d[BYTE_W-1:0] = wr_data[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reg_q <= CFG_RST;
    else if (wr_en) reg_q <= reg_d;
  end

  assign cfg_q   = cfg_t'(reg_q);
  assign cfg_d   = cfg_t'(reg_d);
  assign cmd_stb = upper_wr;

endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan
  import adc_seq_pkg::*;
(
  input  logic [MUX_W-1:0] chan,
  output logic [CH_W-1:0]  pos_ch,
  output logic [MUX_W-1:0] neg_ch
);

  localparam logic [MUX_W-1:0] COM_SEL = MUX_W'(1 << CH_W);

  always_comb begin
    pos_ch = chan[CH_W-1:0];
    if (chan[MUX_W-1]) neg_ch = COM_SEL;
    else               neg_ch = {1'b0, chan[CH_W-1:1], ~chan[0]};
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CONV_CLKS = 44,
  parameter int TRIM_CLKS = 78,
  parameter int CAL_CLKS  = 4946,
  parameter int ACQ_CLKS0 = 9,
  parameter int ACQ_CLKS1 = 15,
  parameter int ACQ_CLKS2 = 47,
  parameter int ACQ_CLKS3 = 79
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_stb,
  input  cmd_e       cmd,
  input  logic       sync_mode_q,
  input  logic       sync_mode_d,
  input  logic [1:0] acq_sel,
  input  logic       sync_in,
  input  logic       rd_last,
  output logic       conv_done,
  output logic       sync_out,
  output logic       rdy_n,
  output logic       stby_n
);

  localparam int MAX_CLKS = imax(imax(imax(CONV_CLKS, TRIM_CLKS), CAL_CLKS),
                                 imax(imax(ACQ_CLKS0, ACQ_CLKS1),
                                      imax(ACQ_CLKS2, ACQ_CLKS3)));
  localparam int CNT_W = $clog2(MAX_CLKS + 1);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             sync_q;
  logic             sync_rise;
  logic             op_end;
  logic             trig;
  logic             rdy_d, stby_d, sout_d;
  int               acq_len;

  assign sync_rise = sync_in & ~sync_q;

  always_comb begin
    unique case (acq_sel)
      2'd0:    acq_len = ACQ_CLKS0;
      2'd1:    acq_len = ACQ_CLKS1;
      2'd2:    acq_len = ACQ_CLKS2;
      default: acq_len = ACQ_CLKS3;
    endcase
  end

  always_comb begin
    st_d      = st_q;
    cnt_d     = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    conv_done = 1'b0;
    op_end    = 1'b0;
    trig      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_stb) begin
          unique case (cmd)
            CMD_CONV: if (!sync_mode_d) begin
              st_d  = ST_ACQ;
              cnt_d = CNT_W'(acq_len - 1);
            end
            CMD_TRIM: begin
              st_d  = ST_TRIM;
              cnt_d = CNT_W'(TRIM_CLKS - 1);
            end
            CMD_CAL: begin
              st_d  = ST_CAL;
              cnt_d = CNT_W'(CAL_CLKS - 1);
            end
            CMD_SLEEP: st_d = ST_SLEEP;
            default: ;
          endcase
        end else if (sync_rise && sync_mode_q) begin
          st_d  = ST_CONV;
          cnt_d = CNT_W'(CONV_CLKS - 1);
          trig  = 1'b1;
        end
      end
      ST_ACQ: if (cnt_q == '0) begin
        st_d  = ST_CONV;
        cnt_d = CNT_W'(CONV_CLKS - 1);
      end
      ST_CONV: if (cnt_q == '0) begin
        st_d      = ST_IDLE;
        conv_done = 1'b1;
      end
      ST_TRIM, ST_CAL: if (cnt_q == '0) begin
        st_d   = ST_IDLE;
        op_end = 1'b1;
      end
      ST_SLEEP: if (cmd_stb && cmd == CMD_WAKE) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rdy_d = rdy_n;
    if (cmd_stb || trig || rd_last) rdy_d = 1'b1;
    if (conv_done || op_end)        rdy_d = 1'b0;
    stby_d = (st_d != ST_SLEEP);
    sout_d = (st_d == ST_CONV) && !sync_mode_d;
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sync_q   <= 1'b0;
      rdy_n    <= 1'b1;
      stby_n   <= 1'b1;
      sync_out <= 1'b0;
    end else begin
      st_q     <= st_d;
      sync_q   <= sync_in;
      rdy_n    <= rdy_d;
      stby_n   <= stby_d;
      sync_out <= sout_d;
    end
  end

endmodule

// File: rtl/adc_seq_rdout.sv
module adc_seq_rdout
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] conv_value,
  input  logic              single,
  input  logic              wide,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);

  localparam int HI_W  = DATA_W - BYTE_W;
  localparam int EXT_W = BYTE_W - HI_W;
  localparam int PAD_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] res_q, res_d;
  logic              hi_q;

  assign res_d   = (single && conv_value[DATA_W-1]) ? '0 : conv_value;
  assign rd_last = rd_en & (wide | hi_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_q <= '0;
    else if (capture) res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hi_q <= 1'b0;
    else if (capture)         hi_q <= 1'b0;
    else if (rd_en && !wide)  hi_q <= ~hi_q;
  end

  always_comb begin
    if (wide)      rd_data = res_q;
    else if (hi_q) rd_data = {{PAD_W{1'b0}}, {EXT_W{res_q[DATA_W-1]}}, res_q[DATA_W-1:BYTE_W]};
    else           rd_data = {{PAD_W{1'b0}}, res_q[BYTE_W-1:0]};
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_CLKS = 44,
  parameter int TRIM_CLKS = 78,
  parameter int CAL_CLKS  = 4946,
  parameter int ACQ_CLKS0 = 9,
  parameter int ACQ_CLKS1 = 15,
  parameter int ACQ_CLKS2 = 47,
  parameter int ACQ_CLKS3 = 79
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] conv_value,
  input  logic              sync_in,
  output logic              sync_out,
  output logic              sync_oe,
  output logic              rdy_n,
  output logic              stby_n,
  output logic [CH_W-1:0]   pos_ch,
  output logic [MUX_W-1:0]  neg_ch
);

  cfg_t cfg_q, cfg_d;
  logic cmd_stb, conv_done, rd_last;

  adc_seq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_q(cfg_q), .cfg_d(cfg_d), .cmd_stb(cmd_stb)
  );

  adc_seq_chan u_chan (
    .chan(cfg_q.chan), .pos_ch(pos_ch), .neg_ch(neg_ch)
  );

  adc_seq_fsm #(
    .CONV_CLKS(CONV_CLKS), .TRIM_CLKS(TRIM_CLKS), .CAL_CLKS(CAL_CLKS),
    .ACQ_CLKS0(ACQ_CLKS0), .ACQ_CLKS1(ACQ_CLKS1),
    .ACQ_CLKS2(ACQ_CLKS2), .ACQ_CLKS3(ACQ_CLKS3)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd(cmd_e'(cfg_d.cmd)),
    .sync_mode_q(cfg_q.sync_in_mode), .sync_mode_d(cfg_d.sync_in_mode),
    .acq_sel(cfg_d.acq), .sync_in(sync_in), .rd_last(rd_last),
    .conv_done(conv_done), .sync_out(sync_out), .rdy_n(rdy_n), .stby_n(stby_n)
  );

  adc_seq_rdout u_rd (
    .clk(clk), .rst_n(rst_n), .capture(conv_done), .conv_value(conv_value),
    .single(cfg_q.single), .wide(cfg_q.wide), .rd_en(rd_en),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  assign sync_oe = ~cfg_q.sync_in_mode;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int CONV_CLKS = 44
)(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             sync_in,
  input logic             sync_out,
  input logic             sync_oe,
  input logic             rdy_n,
  input logic             stby_n,
  input logic [CH_W-1:0]  pos_ch,
  input logic [MUX_W-1:0] neg_ch
);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= '0;
    else if (sync_out) hi_cnt <= hi_cnt + 1'b1;
    else               hi_cnt <= '0;
  end

  // R5
  sync_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> sync_oe);

  // R5
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_out) |-> hi_cnt == 16'(CONV_CLKS));

  // R4
  chan_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_ch != {1'b0, pos_ch});

  // R12
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |-> (!sync_out && rdy_n));

  // R12
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stby_n) |-> $past(wr_en));

  // R10
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |-> ($past(wr_en) || $past(rd_en) || $past(sync_in)));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.CONV_CLKS(CONV_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sync_in(sync_in),
  .sync_out(sync_out), .sync_oe(sync_oe), .rdy_n(rdy_n), .stby_n(stby_n),
  .pos_ch(pos_ch), .neg_ch(neg_ch)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [12:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [12:0] rd_data;
  logic [12:0] conv_value = '0;
  logic        sync_in = 1'b0;
  logic        sync_out, sync_oe, rdy_n, stby_n;
  logic [2:0]  pos_ch;
  logic [3:0]  neg_ch;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int due_q[$];
  string tag_q[$];
  logic prev_rdy = 1'b1;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .conv_value(conv_value),
    .sync_in(sync_in), .sync_out(sync_out), .sync_oe(sync_oe),
    .rdy_n(rdy_n), .stby_n(stby_n), .pos_ch(pos_ch), .neg_ch(neg_ch)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] cw(input logic wide, input logic [2:0] cmd,
      input logic smode, input logic hb, input logic se,
      input logic [1:0] acq, input logic [3:0] ch);
    return {wide, cmd, smode, hb, se, acq, ch};
  endfunction

  // monitor: every fall of rdy_n must match the head of the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rdy && !rdy_n) begin
        if (due_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7/R13 unexpected ready at cycle %0d expected none", cyc);
        end else begin
          int exp_c;
          string t;
          exp_c = due_q.pop_front();
          t = tag_q.pop_front();
          chk(t, cyc, exp_c);
        end
      end
      prev_rdy = rdy_n;
    end
  end

  task automatic wr(input logic [12:0] d, output int stamp);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    stamp = cyc;
  endtask

  task automatic rd(output logic [12:0] d);
    d = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_rdy(input int limit, output int hi);
    hi = 0;
    for (int i = 0; i < limit; i++) begin
      if (sync_out) hi++;
      if (!rdy_n) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sync_out) hi++;
    end
  endtask

  task automatic conv13(input logic se, input logic [1:0] acq, input int acq_len,
      input logic [12:0] val, input logic [12:0] exp, input string tag);
    int st, hi;
    logic [12:0] d;
    conv_value = val;
    wr(cw(1'b1, 3'd1, 1'b0, 1'b0, se, acq, 4'd0), st);
    due_q.push_back(st + acq_len + 44); tag_q.push_back({tag, " ready timing"});
    wait_rdy(400, hi);
    chk({tag, " sync_out width"}, hi, 44);
    rd(d);
    chk({tag, " result"}, d, exp);
    chk("R9 rdy_n after wide read", rdy_n, 1);
  endtask

  initial begin
    int st, hi;
    logic [12:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdy_n", rdy_n, 1);
    chk("R1 stby_n", stby_n, 1);
    chk("R1 sync_oe", sync_oe, 0);
    chk("R1 sync_out", sync_out, 0);
    chk("R1 pos_ch", pos_ch, 0);
    chk("R1 neg_ch", neg_ch, 1);

    // R3 byte-mode low write with high-byte select, channel code 10
    wr(13'h08A, st);
    chk("R4 code10 pos", pos_ch, 2);
    chk("R4 code10 neg", neg_ch, 8);
    chk("R3 low write starts nothing", rdy_n, 1);
    // R3 upper byte: wide=1, cmd=0, sync output mode
    wr(13'h010, st);
    chk("R2 sync_oe output mode", sync_oe, 1);
    // R2 wide write
    wr(cw(1, 0, 0, 0, 0, 0, 4'd3), st);
    chk("R4 code3 pos", pos_ch, 3);
    chk("R4 code3 neg", neg_ch, 2);
    wr(cw(1, 0, 0, 0, 0, 0, 4'd6), st);
    chk("R4 code6 pos", pos_ch, 6);
    chk("R4 code6 neg", neg_ch, 7);

    // R5 each acquisition length
    conv13(0, 2'd0, 9,  13'h0123, 13'h0123, "R5 acq0");
    conv13(0, 2'd1, 15, 13'h0456, 13'h0456, "R5 acq1");
    conv13(0, 2'd2, 47, 13'h0789, 13'h0789, "R5 acq2");
    conv13(0, 2'd3, 79, 13'h0ABC, 13'h0ABC, "R5 acq3");

    // R8 single-ended clamp
    conv13(0, 2'd0, 9, 13'h1F00, 13'h1F00, "R8 signed kept");
    conv13(1, 2'd0, 9, 13'h1F00, 13'h0000, "R8 negative clamped");
    conv13(1, 2'd0, 9, 13'h0FFF, 13'h0FFF, "R8 positive kept");

    // R10 command write raises ready
    conv_value = 13'h0055;
    wr(cw(1, 1, 0, 0, 0, 0, 0), st);
    due_q.push_back(st + 53); tag_q.push_back("R10 setup ready");
    wait_rdy(400, hi);
    wr(cw(1, 0, 0, 0, 0, 0, 0), st);
    chk("R10 rdy_n after command write", rdy_n, 1);

    // R6 sync-input conversion, R7 ignored second edge
    wr(cw(1, 0, 1, 0, 0, 0, 0), st);
    chk("R6 sync_oe input mode", sync_oe, 0);
    conv_value = 13'h0321;
    sync_in = 1'b1;
    @(negedge clk);
    st = cyc;
    due_q.push_back(st + 44); tag_q.push_back("R6 sync-in ready timing");
    repeat (10) @(negedge clk);
    sync_in = 1'b0;
    @(negedge clk);
    sync_in = 1'b1;
    wait_rdy(400, hi);
    chk("R6 sync_out low in input mode", hi, 0);
    rd(d);
    chk("R6 sync-in result", d, 13'h0321);
    idle(60, hi);
    chk("R7 no second result", rdy_n, 1);
    sync_in = 1'b0;

    // R3/R9 byte mode
    wr(cw(0, 0, 0, 0, 0, 0, 0), st);
    conv_value = 13'h1A5C;
    wr({5'd0, cw(0, 0, 0, 1, 0, 2'd1, 4'd5)[7:0]}, st);
    chk("R3 byte low pos", pos_ch, 5);
    chk("R3 byte low neg", neg_ch, 4);
    wr(13'h002, st);
    due_q.push_back(st + 15 + 44); tag_q.push_back("R3 upper byte starts conversion");
    wait_rdy(400, hi);
    rd(d);
    chk("R9 low byte", d, 13'h005C);
    chk("R9 rdy_n after first byte", rdy_n, 0);
    rd(d);
    chk("R9 high byte sign-extended", d, 13'h00FA);
    chk("R9 rdy_n after second byte", rdy_n, 1);
    wr(13'h007, st);
    chk("R3 select cleared, low byte pos", pos_ch, 7);
    chk("R3 select cleared, low byte neg", neg_ch, 6);
    wr(13'h080, st);
    wr(13'h010, st);

    // R11 trim, R13 command during busy ignored
    wr(cw(1, 2, 0, 0, 0, 0, 0), st);
    due_q.push_back(st + 78); tag_q.push_back("R11 trim timing");
    repeat (5) @(negedge clk);
    wr(cw(1, 1, 0, 0, 0, 0, 0), st);
    wait_rdy(400, hi);
    idle(150, hi);
    chk("R13 busy command ignored", rdy_n, 0);
    chk("R13 no conversion", hi, 0);
    wr(cw(1, 3, 0, 0, 0, 0, 0), st);
    due_q.push_back(st + 4946); tag_q.push_back("R11 calibration timing");
    wait_rdy(6000, hi);

    // R12 standby
    wr(cw(1, 4, 0, 0, 0, 0, 0), st);
    chk("R12 stby_n low", stby_n, 0);
    wr(cw(1, 1, 0, 0, 0, 0, 0), st);
    idle(150, hi);
    chk("R12 convert ignored rdy_n", rdy_n, 1);
    chk("R12 convert ignored sync_out", hi, 0);
    chk("R12 still in standby", stby_n, 0);
    wr(cw(1, 0, 0, 0, 0, 0, 0), st);
    chk("R12 stby_n high after wake", stby_n, 1);
    conv13(0, 2'd0, 9, 13'h0777, 13'h0777, "R12 conversion after wake");

    repeat (5) @(negedge clk);
    chk("R5 no pending results", due_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule